// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller

This block puts two eight-input priority interrupt controllers together to form one unit with fifteen usable request lines. The second controller (the slave) takes request lines 8 to 15 and drives its own interrupt output into input 2 of the first controller (the master). Only the master presents an interrupt to the processor. The processor answers with two acknowledge strobes. On the first strobe the winning request enters service. After the second strobe an 8-bit vector is returned. It comes from the master, or from the slave when the master's winner is its cascade input.

The master tells the slave that it owns the acknowledge by driving a fixed code on a 3-bit internal cascade select bus. This bus is brought out as an output so it can be observed. Each controller has its own command strobe, and both share an opcode and argument. The commands cover end-of-interrupt, the vector base, the input mask, the per-line trigger mode and automatic end-of-interrupt. Automatic end-of-interrupt works on the master only.

Top module: `irq_cascade_pair`

## Requirements
- R1: Lines `irq_in[1:0]` and `irq_in[7:3]` feed master inputs 1:0 and 7:3. Lines `irq_in[15:8]` feed slave inputs 7:0. Master input 2 is driven only by the slave's interrupt, so `irq_in[2]` has no effect on any output.
- R2: Within each controller, priority is fixed with input 0 highest. All slave lines share the slot of master input 2. An in-service input blocks requests on its own input and on every input of lower priority. `int_out` is high exactly when the master has an unblocked pending request.
- R3: Each line has a trigger-mode bit. With 0 (edge), a low-to-high transition raises one request, which holds only while the line stays high. An acknowledged edge request does not come back while the line stays high. With 1 (level), the line requests whenever it is high, including again after end-of-interrupt.
- R4: An acknowledge is two single-cycle `inta` strobes. The first puts the winner in service. `vec_valid` is high for one cycle, the cycle after the second strobe, and `vec_out` holds the vector then.
- R5: The vector is the owning controller's 5-bit base followed by the 3-bit input number. After reset the master base is 5'h01 (vectors 0x08 to 0x0F) and the slave base is 5'h0E (vectors 0x70 to 0x77).
- R6: `cas_sel` is 3'b010 from the first strobe's cycle through the second strobe's cycle when the slave owns the acknowledge. At all other times it is 3'b000. The slave answers only to code 3'b010.
- R7: If no request is pending at the first strobe, the master returns its base with input number 7. No in-service bit changes.
- R8: The non-specific end-of-interrupt command clears the highest-priority in-service bit. The specific one clears the bit given by `cmd_arg[2:0]`.
- R9: A slave-sourced interrupt needs an end-of-interrupt on both controllers before another slave request is presented. A slave request behind an in-service master input 0 or 1 stays hidden until that bit is cleared.
- R10: With automatic end-of-interrupt on, the master clears the acknowledged in-service bit at the second strobe. The same command written to the slave has no effect.
- R11: A mask bit of 1 hides that input's request. An edge captured while the input is masked is presented once the input is unmasked, provided the line is still high.
- R12: After reset, `int_out`, `vec_valid`, `vec_out` and `cas_sel` are all zero. Masks, trigger modes and automatic end-of-interrupt are all cleared.
- R13: A command is applied when `mst_cmd_we` or `slv_cmd_we` is high. Opcodes are 0 non-specific end-of-interrupt, 1 specific end-of-interrupt, 2 base from `cmd_arg[7:3]`, 3 mask from `cmd_arg`, 4 trigger modes from `cmd_arg`, and 5 automatic end-of-interrupt from `cmd_arg[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; bit 2 unused |
| mst_cmd_we | input | 1 | Command strobe for the master |
| slv_cmd_we | input | 1 | Command strobe for the slave |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 8 | Command argument |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| int_out | output | 1 | Interrupt to the processor |
| cas_sel | output | 3 | Cascade select bus |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | Vector valid, one cycle |

## Verification
The ownership assertion expects software to follow the nested discipline. A slave can only gain a new in-service bit through the master's cascade input, and that requires the master's in-service bit 2 to be clear beforehand. This holds only if end-of-interrupt commands are never issued in the same cycle as an acknowledge strobe. The acknowledge assertions also expect `inta` to come as isolated pairs of strobes. The stimulus meets both conditions. Every `inta` strobe lasts one cycle and is followed by a low cycle. Commands are issued only between complete acknowledge pairs. For slave-sourced interrupts, the slave end-of-interrupt is always written before the master one.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int BASE_W = 5;
    localparam int VEC_W  = BASE_W + IDX_W;
    localparam int CAS_W  = 3;

    localparam logic [IDX_W-1:0] CASCADE_PORT   = IDX_W'(2);
    localparam logic [IDX_W-1:0] SPURIOUS_IDX   = IDX_W'(LINES - 1);
    localparam logic [CAS_W-1:0] CAS_SLAVE_CODE = 3'b010;
    localparam logic [CAS_W-1:0] CAS_IDLE       = 3'b000;

    typedef enum logic [2:0] {
        OP_EOI_ANY = 3'd0,
        OP_EOI_SEL = 3'd1,
        OP_BASE    = 3'd2,
        OP_MASK    = 3'd3,
        OP_TRIG    = 3'd4,
        OP_AUTO    = 3'd5
    } cmd_op_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Highest-priority pending input not shadowed by an in-service bit at or above it.
    function automatic pick_t pick_winner(input logic [LINES-1:0] pend,
                                          input logic [LINES-1:0] isr);
        pick_t r;
        logic  stop;
        r    = '0;
        stop = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop = 1'b1;
                end else if (pend[i]) begin
                    r.hit = 1'b1;
                    r.idx = IDX_W'(i);
                    stop  = 1'b1;
                end
            end
        end
        return r;
    endfunction

    function automatic pick_t first_set(input logic [LINES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [LINES-1:0] one_hot(input logic [IDX_W-1:0] idx);
        logic [LINES-1:0] r;
        r      = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_cascade_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE_RST    = 5'h01,
    parameter logic [LINES-1:0]  FORCE_LEVEL = '0,
    parameter bit                AUTO_EOI_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  req_in,
    input  logic              cmd_we,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_arg,
    input  logic              ack_first,
    input  logic              ack_last,
    output logic              int_o,
    output logic              win_hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic [VEC_W-1:0]  vec_o,
    output logic [LINES-1:0]  isr_o
);

    logic [LINES-1:0]  prev_q, lat_q, isr_q, mask_q, lvl_q;
    logic [LINES-1:0]  lat_n, isr_n, pend, lvl_eff;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  acked_q;
    logic              spur_q;
    logic              auto_eoi;
    pick_t             win, top_isr;
    cmd_op_e           op;

    assign op      = cmd_op_e'(cmd_op);
    assign lvl_eff = lvl_q | FORCE_LEVEL;
    assign pend    = req_in & (lvl_eff | lat_q) & ~mask_q;
    assign win     = pick_winner(pend, isr_q);
    assign top_isr = first_set(isr_q);

    always_comb begin
        lat_n = (lat_q | (req_in & ~prev_q)) & req_in;
        if (ack_first && win.hit) begin
            lat_n = lat_n & ~one_hot(win.idx);
        end
    end

    always_comb begin
        isr_n = isr_q;
        if (ack_first && win.hit) begin
            isr_n = isr_n | one_hot(win.idx);
        end
        if (ack_last && auto_eoi && !spur_q) begin
            isr_n = isr_n & ~one_hot(acked_q);
        end
        if (cmd_we) begin
            if (op == OP_EOI_ANY && top_isr.hit) begin
                isr_n = isr_n & ~one_hot(top_isr.idx);
            end else if (op == OP_EOI_SEL) begin
                isr_n = isr_n & ~one_hot(cmd_arg[IDX_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            lat_q   <= '0;
            isr_q   <= '0;
            mask_q  <= '0;
            lvl_q   <= '0;
            base_q  <= BASE_RST;
            acked_q <= '0;
            spur_q  <= 1'b0;
        end else begin
            prev_q <= req_in;
            lat_q  <= lat_n;
            isr_q  <= isr_n;
            if (ack_first) begin
                acked_q <= win.hit ? win.idx : SPURIOUS_IDX;
                spur_q  <= !win.hit;
            end
            if (cmd_we) begin
                case (op)
                    OP_BASE: base_q <= cmd_arg[7 -: BASE_W];
                    OP_MASK: mask_q <= cmd_arg;
                    OP_TRIG: lvl_q  <= cmd_arg;
                    default: ;
                endcase
            end
        end
    end

    generate
        if (AUTO_EOI_OK) begin : g_auto
            logic auto_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    auto_q <= 1'b0;
                end else if (cmd_we && op == OP_AUTO) begin
                    auto_q <= cmd_arg[0];
                end
            end
            assign auto_eoi = auto_q;
        end else begin : g_no_auto
            assign auto_eoi = 1'b0;
        end
    endgenerate

    assign int_o   = win.hit;
    assign win_hit = win.hit;
    assign win_idx = win.idx;
    assign vec_o   = {base_q, acked_q};
    assign isr_o   = isr_q;

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_cascade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inta,
    input  logic              mst_hit,
    input  logic [IDX_W-1:0]  mst_idx,
    input  logic [VEC_W-1:0]  mst_vec,
    input  logic [VEC_W-1:0]  slv_vec,
    output logic              pulse_first,
    output logic              pulse_last,
    output logic              slv_sel,
    output logic [CAS_W-1:0]  cas_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_valid
);

    logic             phase_q;
    logic [CAS_W-1:0] cas_q;
    logic [VEC_W-1:0] vec_q;
    logic             vv_q;
    logic             pick_slave;

    assign pulse_first = inta && !phase_q;
    assign pulse_last  = inta && phase_q;
    assign pick_slave  = mst_hit && (mst_idx == CASCADE_PORT);
    assign cas_o       = pulse_first ? (pick_slave ? CAS_SLAVE_CODE : CAS_IDLE) : cas_q;
    assign slv_sel     = (cas_o == CAS_SLAVE_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            cas_q   <= CAS_IDLE;
            vec_q   <= '0;
            vv_q    <= 1'b0;
        end else begin
            phase_q <= phase_q ^ inta;
            if (pulse_first) begin
                cas_q <= cas_o;
            end else if (pulse_last) begin
                cas_q <= CAS_IDLE;
            end
            vv_q <= pulse_last;
            if (pulse_last) begin
                vec_q <= slv_sel ? slv_vec : mst_vec;
            end
        end
    end

    assign vec_o     = vec_q;
    assign vec_valid = vv_q;

endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
    import irq_cascade_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] irq_in,
    input  logic        mst_cmd_we,
    input  logic        slv_cmd_we,
    input  logic [2:0]  cmd_op,
    input  logic [7:0]  cmd_arg,
    input  logic        inta,
    output logic        int_out,
    output logic [2:0]  cas_sel,
    output logic [7:0]  vec_out,
    output logic        vec_valid
);

    localparam logic [LINES-1:0] CASCADE_MASK = one_hot(CASCADE_PORT);

    logic [LINES-1:0] mst_req, slv_req;
    logic [LINES-1:0] mst_isr, slv_isr;
    logic             slv_int, slv_hit_unused, mst_hit;
    logic [IDX_W-1:0] slv_idx_unused, mst_idx;
    logic [VEC_W-1:0] mst_vec, slv_vec;
    logic             p_first, p_last, slv_sel;
    logic             unused_line2;

    assign unused_line2 = irq_in[CASCADE_PORT];
    assign slv_req      = irq_in[2*LINES-1:LINES];

    always_comb begin
        mst_req               = irq_in[LINES-1:0];
        mst_req[CASCADE_PORT] = slv_int;
    end

    irq_ctrl_unit #(
        .BASE_RST    (5'h0E),
        .FORCE_LEVEL ('0),
        .AUTO_EOI_OK (1'b0)
    ) u_slave (
        .clk       (clk),
        .rst       (rst),
        .req_in    (slv_req),
        .cmd_we    (slv_cmd_we),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .ack_first (p_first && slv_sel),
        .ack_last  (p_last && slv_sel),
        .int_o     (slv_int),
        .win_hit   (slv_hit_unused),
        .win_idx   (slv_idx_unused),
        .vec_o     (slv_vec),
        .isr_o     (slv_isr)
    );

    irq_ctrl_unit #(
        .BASE_RST    (5'h01),
        .FORCE_LEVEL (CASCADE_MASK),
        .AUTO_EOI_OK (1'b1)
    ) u_master (
        .clk       (clk),
        .rst       (rst),
        .req_in    (mst_req),
        .cmd_we    (mst_cmd_we),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .ack_first (p_first),
        .ack_last  (p_last),
        .int_o     (int_out),
        .win_hit   (mst_hit),
        .win_idx   (mst_idx),
        .vec_o     (mst_vec),
        .isr_o     (mst_isr)
    );

    irq_ack_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .inta        (inta),
        .mst_hit     (mst_hit),
        .mst_idx     (mst_idx),
        .mst_vec     (mst_vec),
        .slv_vec     (slv_vec),
        .pulse_first (p_first),
        .pulse_last  (p_last),
        .slv_sel     (slv_sel),
        .cas_o       (cas_sel),
        .vec_o       (vec_out),
        .vec_valid   (vec_valid)
    );

endmodule

// File: rtl/irq_cascade_checks.sv
module irq_cascade_checks (
    input logic       clk,
    input logic       rst,
    input logic       inta,
    input logic [2:0] cas_sel,
    input logic       vec_valid,
    input logic [7:0] mst_isr,
    input logic [7:0] slv_isr
);

    // R6: only the idle code or the slave code ever appears on the bus
    assert_cas_code_R6: assert property (@(posedge clk) disable iff (rst)
        (cas_sel == 3'b000) || (cas_sel == 3'b010));

    // R6: the slave code first appears in a cycle that carries an acknowledge strobe
    assert_cas_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_sel[1]) |-> inta);

    // R4: a vector is only valid right after an acknowledge strobe
    assert_vec_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta));

    // R9: the slave gains an in-service bit only while the master takes its cascade input into service
    assert_slave_owner_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(slv_isr) > $countones($past(slv_isr))) |-> (mst_isr[2] && !$past(mst_isr[2])));

endmodule

bind irq_cascade_pair irq_cascade_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .inta      (inta),
    .cas_sel   (cas_sel),
    .vec_valid (vec_valid),
    .mst_isr   (mst_isr),
    .slv_isr   (slv_isr)
);

// File: tb/sim_irq_cascade_pair.sv
`timescale 1ns/1ps
module sim_irq_cascade_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic        mst_cmd_we = 1'b0, slv_cmd_we = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_arg = '0;
    logic        inta = 1'b0;
    logic        int_out, vec_valid;
    logic [2:0]  cas_sel;
    logic [7:0]  vec_out;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_cascade_pair u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .mst_cmd_we(mst_cmd_we),
        .slv_cmd_we(slv_cmd_we), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .inta(inta),
        .int_out(int_out), .cas_sel(cas_sel), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_lat, m_isr, m_mask, m_lvl, m_prev, s_lat, s_isr, s_mask, s_lvl, s_prev;
    logic [4:0] m_base, s_base;
    logic [2:0] m_ack, s_ack, m_cas;
    logic       m_spur, s_spur, m_auto, m_ph, m_vv;
    logic [7:0] m_vec;
    logic       e_mhit, e_shit, e_p1, e_p2;
    logic [2:0] e_midx, e_sidx, e_cas;
    logic [7:0] e_mreq;

    task automatic pick(input logic [7:0] pend, input logic [7:0] isr,
                        output logic hit, output logic [2:0] idx);
        hit = 0; idx = 0;
        for (int i = 7; i >= 0; i--) begin
            if (isr[i]) hit = 0;
            else if (pend[i]) begin hit = 1; idx = 3'(i); end
        end
    endtask

    task automatic m_eval();
        pick(irq_in[15:8] & (s_lvl | s_lat) & ~s_mask, s_isr, e_shit, e_sidx);
        e_mreq = {irq_in[7:3], e_shit, irq_in[1:0]};
        pick(e_mreq & (m_lvl | 8'h04 | m_lat) & ~m_mask, m_isr, e_mhit, e_midx);
        e_p1  = inta && !m_ph;
        e_p2  = inta && m_ph;
        e_cas = e_p1 ? ((e_mhit && e_midx == 3'd2) ? 3'b010 : 3'b000) : m_cas;
    endtask

    function automatic logic [7:0] lowest_clear(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) begin v[i] = 1'b0; return v; end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lat = 0; m_isr = 0; m_mask = 0; m_lvl = 0; m_prev = 0;
            s_lat = 0; s_isr = 0; s_mask = 0; s_lvl = 0; s_prev = 0;
            m_base = 5'h01; s_base = 5'h0E; m_ack = 0; s_ack = 0; m_spur = 0; s_spur = 0;
            m_auto = 0; m_ph = 0; m_vv = 0; m_vec = 0; m_cas = 0;
        end else begin
            logic sel;
            logic [7:0] sreq, nml, nsl, nmi, nsi;
            m_eval();
            sel  = (e_cas == 3'b010);
            sreq = irq_in[15:8];
            nml = (m_lat | (e_mreq & ~m_prev)) & e_mreq;
            nsl = (s_lat | (sreq & ~s_prev)) & sreq;
            nmi = m_isr; nsi = s_isr;
            if (e_p1 && e_mhit) begin nml[e_midx] = 0; nmi[e_midx] = 1; end
            if (e_p1 && sel)    begin nsl[e_sidx] = 0; nsi[e_sidx] = 1; end
            if (e_p2 && m_auto && !m_spur) nmi[m_ack] = 0;
            if (mst_cmd_we) begin
                case (cmd_op)
                    3'd0: nmi = lowest_clear(m_isr);
                    3'd1: nmi[cmd_arg[2:0]] = 0;
                    3'd2: m_base = cmd_arg[7:3];
                    3'd3: m_mask = cmd_arg;
                    3'd4: m_lvl = cmd_arg;
                    3'd5: m_auto = cmd_arg[0];
                    default: ;
                endcase
            end
            if (slv_cmd_we) begin
                case (cmd_op)
                    3'd0: nsi = lowest_clear(s_isr);
                    3'd1: nsi[cmd_arg[2:0]] = 0;
                    3'd2: s_base = cmd_arg[7:3];
                    3'd3: s_mask = cmd_arg;
                    3'd4: s_lvl = cmd_arg;
                    default: ;
                endcase
            end
            m_vv = e_p2;
            if (e_p2) m_vec = sel ? {s_base, s_spur ? 3'd7 : s_ack} : {m_base, m_spur ? 3'd7 : m_ack};
            if (e_p1) begin m_ack = e_mhit ? e_midx : 3'd7; m_spur = !e_mhit; end
            if (e_p1 && sel) begin s_ack = e_sidx; s_spur = 0; end
            if (e_p1) m_cas = e_cas; else if (e_p2) m_cas = 3'b000;
            m_ph = m_ph ^ inta;
            m_lat = nml; s_lat = nsl; m_isr = nmi; s_isr = nsi;
            m_prev = e_mreq; s_prev = sreq;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            m_eval();
            chk(int_out === e_mhit, "R2 model int_out", int'(int_out), int'(e_mhit));
            chk(cas_sel === e_cas, "R6 model cas_sel", int'(cas_sel), int'(e_cas));
            chk(vec_valid === m_vv, "R4 model vec_valid", int'(vec_valid), int'(m_vv));
            if (m_vv) chk(vec_out === m_vec, "R5 model vec_out", int'(vec_out), int'(m_vec));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line(input int n, input logic v);
        @(negedge clk); irq_in[n] = v;
        cyc(2);
    endtask

    task automatic cmd(input bit to_slave, input logic [2:0] op, input logic [7:0] arg);
        @(negedge clk);
        mst_cmd_we = !to_slave; slv_cmd_we = to_slave; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        mst_cmd_we = 0; slv_cmd_we = 0;
        cyc(1);
    endtask

    task automatic ack(input string req, input logic [7:0] exp_vec, input logic [2:0] exp_cas);
        logic [2:0] c1, c2;
        @(negedge clk); inta = 1; #1 c1 = cas_sel;
        @(negedge clk); inta = 0;
        @(negedge clk); inta = 1; #1 c2 = cas_sel;
        @(negedge clk);
        chk(vec_valid === 1'b1, {req, " vec_valid"}, int'(vec_valid), 1);
        chk(vec_out === exp_vec, {req, " vector"}, int'(vec_out), int'(exp_vec));
        chk(c1 === exp_cas, "R6 cas on first strobe", int'(c1), int'(exp_cas));
        chk(c2 === exp_cas, "R6 cas on second strobe", int'(c2), int'(exp_cas));
        inta = 0;
        #1 chk(cas_sel === 3'b000, "R6 cas idle after acknowledge", int'(cas_sel), 0);
        cyc(1);
    endtask

    task automatic expect_int(input string req, input logic exp);
        @(negedge clk);
        chk(int_out === exp, req, int'(int_out), int'(exp));
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        @(negedge clk); rst = 0;
        // R12 reset state
        chk(int_out === 0, "R12 int_out", int'(int_out), 0);
        chk(vec_valid === 0, "R12 vec_valid", int'(vec_valid), 0);
        chk(vec_out === 0, "R12 vec_out", int'(vec_out), 0);
        chk(cas_sel === 0, "R12 cas_sel", int'(cas_sel), 0);

        // R1: line 2 has no effect
        line(2, 1); expect_int("R1 line 2 ignored", 0); line(2, 0);

        // R3/R4/R5: master edge request
        line(3, 1); expect_int("R3 edge request", 1);
        ack("R5 master irq3", 8'h0B, 3'b000);
        cmd(0, 3'd0, 8'h00);
        expect_int("R3 edge held high no repeat", 0);
        line(3, 0);

        // R9: slave request waits behind master input 1
        line(1, 1); ack("R4 master irq1", 8'h09, 3'b000);
        line(12, 1); expect_int("R9 slave hidden behind irq1", 0);
        cmd(0, 3'd0, 8'h00); expect_int("R9 slave shown after master eoi", 1);
        ack("R6 slave irq12", 8'h74, 3'b010);
        cmd(1, 3'd0, 8'h00);
        line(9, 1); expect_int("R9 slave eoi alone insufficient", 0);
        cmd(0, 3'd0, 8'h00); expect_int("R9 both eoi done", 1);
        ack("R9 slave irq9", 8'h71, 3'b010);
        cmd(1, 3'd0, 8'h00); cmd(0, 3'd0, 8'h00);
        line(1, 0); line(9, 0); line(12, 0);

        // R7: spurious acknowledge
        line(4, 1); line(4, 0); expect_int("R7 dropped request", 0);
        ack("R7 spurious", 8'h0F, 3'b000);
        line(7, 1); expect_int("R7 no in-service after spurious", 1);
        ack("R7 real irq7", 8'h0F, 3'b000); cmd(0, 3'd0, 8'h00); line(7, 0);

        // R8: nesting and both end-of-interrupt forms
        line(5, 1); ack("R8 irq5", 8'h0D, 3'b000);
        line(3, 1); expect_int("R8 higher nests", 1);
        ack("R8 irq3", 8'h0B, 3'b000);
        line(6, 1); expect_int("R2 irq6 blocked", 0);
        cmd(0, 3'd0, 8'h00); expect_int("R8 nonspecific cleared irq3 only", 0);
        cmd(0, 3'd1, 8'h05); expect_int("R8 specific cleared irq5", 1);
        ack("R8 irq6", 8'h0E, 3'b000); cmd(0, 3'd0, 8'h00);
        line(3, 0); line(5, 0); line(6, 0);

        // R3: level mode on input 5
        cmd(0, 3'd4, 8'h20);
        line(5, 1); ack("R3 level irq5", 8'h0D, 3'b000);
        cmd(0, 3'd0, 8'h00); expect_int("R3 level repeats", 1);
        line(5, 0); expect_int("R3 level drop", 0);
        cmd(0, 3'd4, 8'h00);

        // R11: mask
        cmd(0, 3'd3, 8'h08);
        line(3, 1); expect_int("R11 masked", 0);
        cmd(0, 3'd3, 8'h00); expect_int("R11 unmasked", 1);
        ack("R11 irq3", 8'h0B, 3'b000); cmd(0, 3'd0, 8'h00); line(3, 0);

        // R10: automatic end-of-interrupt on master, ignored on slave
        cmd(0, 3'd5, 8'h01); cmd(1, 3'd5, 8'h01);
        line(4, 1); ack("R10 irq4", 8'h0C, 3'b000);
        line(6, 1); expect_int("R10 master auto cleared", 1);
        ack("R10 irq6", 8'h0E, 3'b000);
        line(8, 1); ack("R10 slave irq8", 8'h70, 3'b010);
        line(9, 1); expect_int("R10 slave auto ignored", 0);
        cmd(1, 3'd0, 8'h00); expect_int("R10 slave eoi releases", 1);
        ack("R10 slave irq9", 8'h71, 3'b010); cmd(1, 3'd0, 8'h00);
        cmd(0, 3'd5, 8'h00);
        line(4, 0); line(6, 0); line(8, 0); line(9, 0);

        // R13/R5: base programming
        cmd(0, 3'd2, 8'h80); cmd(1, 3'd2, 8'h40);
        line(4, 1); ack("R13 master base", 8'h84, 3'b000); cmd(0, 3'd0, 8'h00);
        line(11, 1); ack("R13 slave base", 8'h43, 3'b010);
        cmd(1, 3'd0, 8'h00); cmd(0, 3'd0, 8'h00);
        expect_int("R13 all clear", 0);

        cyc(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule